// File: doc/BRIEF.md
# Reloadable Periodic Tick Timer

This block is a single up-counting interval timer behind a small byte-wide register bus. It produces a periodic tick interrupt for an operating system. Software first loads a terminal value into three write-only byte lanes. It then turns on counting and interrupt generation through a control register. The counter starts at zero, climbs to the terminal value and folds back to zero. Each fold raises a level interrupt, and that interrupt stays up until software drops the interrupt-enable bit. Setting the bit again arms the next tick.

The running count can be read while the timer runs. Reading the lowest count byte freezes the whole count into a snapshot register. The three higher count bytes are then read from that frozen copy, so a multi-byte read is consistent. Each read byte carries its count field in a sparse layout, described in R7. A rate input tells the block whether the bus clock runs at twice the count rate; if so, the counter advances on every second clock. The counter width is a parameter: 22 bits by default, 19 bits for a reduced variant.

Top module: `ptick_timer`

## Requirements
- R1: After a synchronous active-high reset, the control register reads 0x00, count byte 0 reads 0x00 and `irq` is low.
- R2: A write to offset 0 loads terminal-value bits 7:0, offset 1 loads bits 15:8, and offset 2 loads bits CNT_W-1:16 from the low CNT_W-16 data bits (6 bits at the default width). The data bits above that are ignored.
- R3: While counting is enabled, each advance adds one to the count. An advance taken when the count equals the active terminal value returns the count to 0 instead, so one period is terminal+1 advances.
- R4: Offset 4 is the control register: bit 0 enables counting and bit 1 enables the interrupt. A read returns the current value of both bits, with bits 7:2 as 0; written data bits 7:2 are discarded.
- R5: While counting is disabled, the count is 0 and the prescaler phase is reset.
- R6: `bus_rdata` is registered. A read issued with `bus_rd` high at a clock edge appears after that edge and holds until the next read. Reading offset 0 returns the live count and copies the count into the snapshot at the same edge; offsets 1, 2 and 3 return fields of the snapshot, not of the live count. Offsets 5 to 7 read 0x00.
- R7: A 6-bit field f is read as the byte {0, f[5], 0, f[4:0]}. Offsets 0, 1 and 2 carry count bits 5:0, 11:6 and 17:12 in that form, and offset 3 carries count bits 21:18 in bits 3:0 with bits 7:4 at 0. Count bits above CNT_W read as 0.
- R8: A return to zero while interrupt-enable is 1 sets `irq` on the next clock, and `irq` stays high while interrupt-enable stays 1. With interrupt-enable at 0, `irq` is low on the next clock and no return to zero sets it.
- R9: With `clk_is_2x` low, the count advances on every enabled clock. With it high, the count advances on every second enabled clock, the first advance coming on the second clock after counting is enabled.
- R10: The active terminal value is taken from the written value while counting is disabled and at each return to zero. A terminal write during a period does not change that period.
- R11: A terminal value of 0 makes every advance a return to zero, so the count stays 0 and `irq` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_is_2x | input | 1 | High when the clock is twice the count rate |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level tick interrupt |

## Verification
Short terminal values of 0, 5 and 9 separate a correct fold point from an off-by-one period. Writing 0xC0 into the top terminal lane shows whether the unused data bits are masked. Runs with `clk_is_2x` high and low tell the divided advance rate from the full one. A long run with the largest terminal value, followed by late reads of the upper count bytes, tells snapshot data from live data. A terminal value changed mid-period shows whether the new value is held off to the next fold. Interrupt-enable is toggled to check acknowledge and re-arm. A seeded random mix of writes, reads and rate changes is compared cycle by cycle against a reference model in the bench.

// File: rtl/ptick_pkg.sv
package ptick_pkg;

    localparam int FULL_W = 22;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        OFS_B0   = 3'd0,
        OFS_B1   = 3'd1,
        OFS_B2   = 3'd2,
        OFS_B3   = 3'd3,
        OFS_CTRL = 3'd4
    } ofs_e;

    typedef struct packed {
        logic irq_en;
        logic cnt_en;
    } ctrl_t;

    // Sparse read layout: field bit 5 sits at byte bit 6, bits 4:0 at 4:0.
    function automatic logic [BYTE_W-1:0] pack6(input logic [5:0] f);
        return {1'b0, f[5], 1'b0, f[4:0]};
    endfunction

endpackage

// File: rtl/ptick_regs.sv
module ptick_regs
    import ptick_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]  term_val,
    output ctrl_t             ctrl_q
);
    localparam int NLANE = (CNT_W + BYTE_W - 1) / BYTE_W;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        localparam int LW = ((CNT_W - BYTE_W*i) < BYTE_W) ? (CNT_W - BYTE_W*i) : BYTE_W;
        logic [LW-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= '0;
            else if (bus_wr && bus_addr == ADDR_W'(i))
                lane_q <= bus_wdata[LW-1:0];
        end
        assign term_val[BYTE_W*i +: LW] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (bus_wr && bus_addr == OFS_CTRL)
            ctrl_q <= '{irq_en: bus_wdata[1], cnt_en: bus_wdata[0]};
    end

endmodule

// File: rtl/ptick_counter.sv
module ptick_counter
    import ptick_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_is_2x,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] term_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] lim_q,
    output logic             wrap,
    output logic             irq
);
    logic phase_q;
    logic adv;
    logic pend_q;

    assign adv  = ctrl.cnt_en && (!clk_is_2x || phase_q);
    assign wrap = adv && (cnt_q == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            cnt_q   <= '0;
            lim_q   <= '0;
        end else if (!ctrl.cnt_en) begin
            phase_q <= 1'b0;
            cnt_q   <= '0;
            lim_q   <= term_val;
        end else begin
            phase_q <= ~phase_q;
            if (wrap) begin
                cnt_q <= '0;
                lim_q <= term_val;
            end else if (adv) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (!ctrl.irq_en)
            pend_q <= 1'b0;
        else if (wrap)
            pend_q <= 1'b1;
    end

    assign irq = pend_q;

endmodule

// File: rtl/ptick_readout.sv
module ptick_readout
    import ptick_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  cnt,
    input  ctrl_t             ctrl,
    output logic [BYTE_W-1:0] bus_rdata
);
    logic [FULL_W-1:0] live;
    logic [FULL_W-1:0] snap_q;

    assign live = FULL_W'(cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q    <= '0;
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                OFS_B0: begin
                    bus_rdata <= pack6(live[5:0]);
                    snap_q    <= live;
                end
                OFS_B1:   bus_rdata <= pack6(snap_q[11:6]);
                OFS_B2:   bus_rdata <= pack6(snap_q[17:12]);
                OFS_B3:   bus_rdata <= {4'b0, snap_q[21:18]};
                OFS_CTRL: bus_rdata <= {6'b0, ctrl.irq_en, ctrl.cnt_en};
                default:  bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/ptick_timer.sv
module ptick_timer
    import ptick_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_is_2x,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] term_val;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic             wrap;
    logic             cnt_en;
    logic             irq_en;

    assign cnt_en = ctrl_q.cnt_en;
    assign irq_en = ctrl_q.irq_en;

    ptick_regs #(.CNT_W(CNT_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .term_val (term_val),
        .ctrl_q   (ctrl_q)
    );

    ptick_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .clk_is_2x(clk_is_2x),
        .ctrl     (ctrl_q),
        .term_val (term_val),
        .cnt_q    (cnt_q),
        .lim_q    (lim_q),
        .wrap     (wrap),
        .irq      (irq)
    );

    ptick_readout #(.CNT_W(CNT_W)) rd_i (
        .clk      (clk),
        .rst      (rst),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .cnt      (cnt_q),
        .ctrl     (ctrl_q),
        .bus_rdata(bus_rdata)
    );

endmodule

// File: rtl/ptick_timer_chk.sv
module ptick_timer_chk #(
    parameter int CNT_W = 22
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_rd,
    input logic [2:0]       bus_addr,
    input logic [7:0]       bus_rdata,
    input logic             irq,
    input logic             cnt_en,
    input logic             irq_en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lim,
    input logic             wrap
);
    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim);

    assert_hold_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> cnt == '0);

    assert_irq_ack_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_en |=> !irq);

    assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && irq_en) |=> irq);

    assert_irq_raise_R8: assert property (@(posedge clk) disable iff (rst)
        (wrap && irq_en) |=> irq);

    assert_ctrl_readback_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd4) |=> bus_rdata == {6'b0, $past(irq_en), $past(cnt_en)});

endmodule

bind ptick_timer ptick_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .cnt_en   (cnt_en),
    .irq_en   (irq_en),
    .cnt      (cnt_q),
    .lim      (lim_q),
    .wrap     (wrap)
);

// File: tb/ptick_timer_tb_top.sv
module ptick_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 22;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_is_2x = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptick_timer #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .clk_is_2x(clk_is_2x),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference model built from the requirements
    logic [CW-1:0] m_rel, m_lim, m_cnt;
    logic          m_en, m_ie, m_ph, m_pend;
    logic [21:0]   m_snap;

    always @(posedge clk) begin
        logic adv, fold;
        if (rst) begin
            m_rel <= '0; m_lim <= '0; m_cnt <= '0;
            m_en <= 0; m_ie <= 0; m_ph <= 0; m_pend <= 0;
        end else begin
            adv  = m_en && (!clk_is_2x || m_ph);
            fold = adv && (m_cnt == m_lim);
            if (!m_en) begin
                m_cnt <= '0; m_lim <= m_rel; m_ph <= 0;
            end else begin
                m_ph <= ~m_ph;
                if (fold) begin m_cnt <= '0; m_lim <= m_rel; end
                else if (adv) m_cnt <= m_cnt + 1'b1;
            end
            m_pend <= m_ie ? (m_pend | fold) : 1'b0;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_rel[7:0]     <= bus_wdata;
                    3'd1: m_rel[15:8]    <= bus_wdata;
                    3'd2: m_rel[CW-1:16] <= bus_wdata[CW-17:0];
                    3'd4: begin m_en <= bus_wdata[0]; m_ie <= bus_wdata[1]; end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] field_byte(input logic [5:0] f);
        return {1'b0, f[5], 1'b0, f[4:0]};
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a, input logic [21:0] live,
                                            input logic [21:0] snap, input logic en, input logic ie);
        case (a)
            3'd0: return field_byte(live[5:0]);
            3'd1: return field_byte(snap[11:6]);
            3'd2: return field_byte(snap[17:12]);
            3'd3: return {4'b0, snap[21:18]};
            3'd4: return {6'b0, ie, en};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input string tag);
        check8(tag, {7'b0, irq}, {7'b0, m_pend});
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, input string tag);
        logic [7:0] e;
        e = exp_read(a, 22'(m_cnt), m_snap, m_en, m_ie);
        if (a == 3'd0) m_snap = 22'(m_cnt);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        check8(tag, bus_rdata, e);
    endtask

    task automatic idle_chk(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk_irq(tag);
        end
    endtask

    task automatic set_term(input logic [21:0] v);
        bus_write(3'd0, v[7:0]);
        bus_write(3'd1, v[15:8]);
        bus_write(3'd2, {2'b0, v[21:16]});
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        m_snap = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check8("R1 irq", {7'b0, irq}, 8'h00);
        bus_read(3'd4, "R1 ctrl");
        bus_read(3'd0, "R1 count");

        // R4 control readback, upper bits discarded
        bus_write(3'd4, 8'hFC);
        bus_read(3'd4, "R4 ctrl 0xFC");
        bus_write(3'd4, 8'h02);
        bus_read(3'd4, "R4 ctrl 0x02");
        bus_write(3'd4, 8'h00);

        // R2 masking of lane 2, R3 period 6
        bus_write(3'd0, 8'h05);
        bus_write(3'd1, 8'h00);
        bus_write(3'd2, 8'hC0);
        bus_write(3'd4, 8'h03);
        for (int i = 0; i < 14; i++) begin
            bus_read(3'd0, "R3 R2 count term 5");
            chk_irq("R2 irq term 5");
        end

        // R8 acknowledge and re-arm
        bus_write(3'd4, 8'h01);
        idle_chk(8, "R8 ack low");
        bus_write(3'd4, 8'h03);
        idle_chk(12, "R8 rearm");

        // R2 middle lane: terminal 256
        bus_write(3'd4, 8'h00);
        set_term(22'h000100);
        bus_write(3'd4, 8'h03);
        for (int i = 0; i < 30; i++) begin
            idle_chk(10, "R2 term 256 irq");
            bus_read(3'd0, "R2 term 256 count");
        end

        // R5 disabled holds zero
        bus_write(3'd4, 8'h00);
        idle_chk(3, "R5 idle");
        bus_read(3'd0, "R5 zero");

        // R9 divided rate
        clk_is_2x = 1'b1;
        set_term(22'd9);
        bus_write(3'd4, 8'h03);
        for (int i = 0; i < 25; i++) bus_read(3'd0, "R9 divided count");
        chk_irq("R9 irq");
        clk_is_2x = 1'b0;
        for (int i = 0; i < 10; i++) bus_read(3'd0, "R9 full count");

        // R10 terminal change mid-period
        bus_write(3'd4, 8'h00);
        set_term(22'd20);
        bus_write(3'd4, 8'h03);
        idle_chk(6, "R10 run");
        bus_write(3'd0, 8'd3);
        for (int i = 0; i < 30; i++) begin
            bus_read(3'd0, "R10 count");
            chk_irq("R10 irq");
        end

        // R11 terminal zero
        bus_write(3'd4, 8'h00);
        set_term(22'd0);
        bus_write(3'd4, 8'h03);
        for (int i = 0; i < 5; i++) begin
            bus_read(3'd0, "R11 count");
            chk_irq("R11 irq");
        end

        // R6 R7 snapshot and packing with a long count
        bus_write(3'd4, 8'h00);
        set_term(22'h3FFFFF);
        bus_write(3'd4, 8'h01);
        repeat (5000) @(negedge clk);
        bus_read(3'd0, "R6 R7 byte0");
        repeat (60) @(negedge clk);
        bus_read(3'd1, "R6 R7 byte1");
        bus_read(3'd2, "R6 R7 byte2");
        bus_read(3'd3, "R6 R7 byte3");
        repeat (3000) @(negedge clk);
        bus_read(3'd0, "R7 byte0 again");
        bus_read(3'd1, "R7 byte1 again");
        bus_read(3'd2, "R7 byte2 again");
        bus_read(3'd5, "R6 unused offset");

        // Random mix
        bus_write(3'd4, 8'h00);
        set_term(22'd7);
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 4)
                bus_read(3'($urandom_range(0, 7)), "R3 R6 random read");
            else if (op == 4)
                bus_write(3'd0, 8'($urandom_range(0, 12)));
            else if (op == 5)
                bus_write(3'd4, 8'($urandom_range(0, 255)));
            else if (op == 6)
                clk_is_2x = 1'($urandom_range(0, 1));
            else
                idle_chk(int'($urandom_range(1, 6)), "R8 random irq");
            chk_irq("R8 random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule